// File: doc/BRIEF.md
# Byte-Wide SPI Shift Engine with CPU Registers

This block is an eight-bit SPI peripheral that a small CPU runs through four byte registers. Software writes the byte to send into a transmit holding register and sets the enable bit. The engine then loads the byte into its shifter, places the first bit on the serial data output, and waits. It moves one bit per serial clock: the input is sampled on the rising edge and the output changes on the falling edge. The clock comes either from an external master or, in master mode, from an internal divider.

After the eighth rising edge, the received byte goes into the receive register and a buffer-full flag is raised. The output line then keeps the last data bit for a software-selected number of system clocks before it returns to idle. Only at that point does the engine raise a completion flag, and that flag can drive an interrupt line. Two pads, serial data out and serial clock, are presented as a value and an output-enable pair. Either pad can be switched to open-drain operation, in which it is only ever pulled low.

The serial clock and serial data inputs are synchronised to the system clock before any edge is detected.

Top module: `spi_eng`

## Requirements
- R1: After reset every register reads 0, the data pad and the clock pad are not driven (both output-enables low), and the interrupt output is low.
- R2: With status bit 7 at 0, the output sends the transmit byte from bit 7 down to bit 0. The first input bit sampled lands in bit 7 of the received byte.
- R3: With status bit 7 at 1, the output sends the transmit byte from bit 0 up to bit 7. The first input bit sampled lands in bit 0 of the received byte.
- R4: A written byte is not shifted until both of these hold: the enable bit (control bit 0) is 1 and a rising serial clock edge arrives. While the engine is enabled and waiting, the output already shows the first bit. While the engine is disabled, clock edges change nothing.
- R5: After the eighth rising edge, the received byte is readable at address 0 and status bit 0 (buffer full) is 1. A read of address 0 clears status bit 0.
- R6: Status bits 6:5 choose a hold time of 8, 16, 24 or 32 system clocks for the codes 0 to 3. Counted from the eighth rising edge at the pin, the output keeps the last data bit for that many clocks. Within 5 further clocks the output returns to the idle level 1 and control bit 7 (done) is set.
- R7: The interrupt output equals done AND the interrupt-enable bit (control bit 2). Writing control with bit 7 at 0 clears done. Writing bit 7 at 1 leaves done unchanged.
- R8: With status bit 3 at 1, the data pad value is 0 and its output-enable is high only while a 0 is sent. With status bit 3 at 0, the output-enable is high whenever the engine is enabled.
- R9: With control bit 1 at 1 (master mode), the engine produces exactly eight clock pulses per byte on the clock pad. With status bit 2 at 1, that pad's value is held at 0 and the line is released for the high phase. In slave mode the clock pad is never driven.
- R10: The register map is: address 0 receive byte (read only), address 1 transmit byte, address 2 status, address 3 control. Status bits 4 and 1 and control bits 6:3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears full on address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| sck_i | input | 1 | Serial clock from pad |
| sck_o | output | 1 | Serial clock pad value |
| sck_oe | output | 1 | Serial clock pad output-enable |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data pad value |
| sdo_oe | output | 1 | Serial data pad output-enable |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Both bit orders are run with asymmetric bytes, so a design that ignored or inverted the order bit would send a mirrored pattern. Every hold code is timed against the eighth rising edge, which exposes a delay that ignores the code, scales it wrongly, or lets the output fall back to idle early. Clock edges given while the engine is disabled must not produce a received byte. Clearing done, reading the receive register, and masking the interrupt are each checked separately, which catches a flag bit that is decoded wrongly. In the open-drain and master-mode cases the bench counts released clock pulses on the line, so a pad that actually drives high, or a generator that produces a ninth pulse, is reported.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_RX   = 2'd0;
   localparam logic [ADDR_W-1:0] A_TX   = 2'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
   localparam logic [ADDR_W-1:0] A_CTRL = 2'd3;

   typedef struct packed {
      logic       lsb_first;
      logic [1:0] hold_sel;
      logic       od_sdo;
      logic       od_sck;
   } cfg_t;

   typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD} st_t;
endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
   import spi_eng_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                rd,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic                rx_load,
   input  logic [DATA_W-1:0]   rx_byte,
   input  logic                tx_take,
   input  logic                xfer_done,
   output cfg_t                cfg,
   output logic                en,
   output logic                master,
   output logic                ie,
   output logic                done,
   output logic                full,
   output logic                tx_pend,
   output logic [DATA_W-1:0]   tx_byte
);
   logic [DATA_W-1:0] rx_q;
   logic [7:0]        stat_v, ctrl_v;
   logic              unused_bits;

   assign unused_bits = ^{wdata[4], wdata[1], wdata[6:3]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         en      <= 1'b0;
         master  <= 1'b0;
         ie      <= 1'b0;
         done    <= 1'b0;
         full    <= 1'b0;
         tx_pend <= 1'b0;
         tx_byte <= '0;
         rx_q    <= '0;
      end else begin
         if (tx_take) tx_pend <= 1'b0;
         if (rd && addr == A_RX) full <= 1'b0;
         if (wr) begin
            case (addr)
               A_TX: begin
                  tx_byte <= wdata;
                  tx_pend <= 1'b1;
               end
               A_STAT: begin
                  cfg.lsb_first <= wdata[7];
                  cfg.hold_sel  <= wdata[6:5];
                  cfg.od_sdo    <= wdata[3];
                  cfg.od_sck    <= wdata[2];
               end
               A_CTRL: begin
                  en     <= wdata[0];
                  master <= wdata[1];
                  ie     <= wdata[2];
                  if (!wdata[7]) done <= 1'b0;
               end
               default: ;
            endcase
         end
         if (xfer_done) done <= 1'b1;
         if (rx_load) begin
            rx_q <= rx_byte;
            full <= 1'b1;
         end
      end
   end

   assign stat_v = {cfg.lsb_first, cfg.hold_sel, 1'b0, cfg.od_sdo, cfg.od_sck, 1'b0, full};
   assign ctrl_v = {done, 4'b0, ie, master, en};

   always_comb begin
      case (addr)
         A_RX:    rdata = rx_q;
         A_TX:    rdata = tx_byte;
         A_STAT:  rdata = DATA_W'(stat_v);
         default: rdata = DATA_W'(ctrl_v);
      endcase
   end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
   import spi_eng_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SYNC_N    = 2,
   parameter int HOLD_UNIT = 8,
   parameter int HALF_DIV  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              master,
   input  logic              lsb_first,
   input  logic [1:0]        hold_sel,
   input  logic              tx_pend,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              sck_in,
   input  logic              sdi_in,
   output logic              tx_take,
   output logic              rx_load,
   output logic [DATA_W-1:0] rx_byte,
   output logic              xfer_done,
   output logic              sdo_bit,
   output logic              sck_gen,
   output logic              hold
);
   localparam int BCW = $clog2(DATA_W);
   localparam int HCW = $clog2(HOLD_UNIT * 4);
   localparam int DCW = $clog2(HALF_DIV + 1);

   st_t               st;
   logic [DATA_W-1:0] tsr, rsr;
   logic [BCW-1:0]    bitcnt;
   logic [HCW-1:0]    hcnt;
   logic [DCW-1:0]    div_cnt;
   logic              sck_s, sdi_s, sck_eff, sck_prev, rise, fall, last_bit;

   // input synchronisers, variant picked by depth
   if (SYNC_N == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) {sck_s, sdi_s} <= '0;
         else        {sck_s, sdi_s} <= {sck_in, sdi_in};
   end else begin : g_syncn
      logic [SYNC_N-1:0] sck_p, sdi_p;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            sck_p <= '0;
            sdi_p <= '0;
         end else begin
            sck_p <= {sck_p[SYNC_N-2:0], sck_in};
            sdi_p <= {sdi_p[SYNC_N-2:0], sdi_in};
         end
      assign sck_s = sck_p[SYNC_N-1];
      assign sdi_s = sdi_p[SYNC_N-1];
   end

   assign sck_eff  = master ? sck_gen : sck_s;
   assign rise     = sck_eff & ~sck_prev;
   assign fall     = ~sck_eff & sck_prev;
   assign last_bit = (bitcnt == BCW'(DATA_W - 1));
   assign rx_byte  = lsb_first ? {sdi_s, rsr[DATA_W-1:1]} : {rsr[DATA_W-2:0], sdi_s};
   assign tx_take  = (st == ST_IDLE) && en && tx_pend;
   assign rx_load  = (st == ST_SHIFT) && en && rise && last_bit;
   assign xfer_done = (st == ST_HOLD) && (hcnt == '0);
   assign hold     = (st == ST_HOLD);
   assign sdo_bit  = (st == ST_IDLE) ? 1'b1 : (lsb_first ? tsr[0] : tsr[DATA_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         tsr      <= '0;
         rsr      <= '0;
         bitcnt   <= '0;
         hcnt     <= '0;
         sck_prev <= 1'b0;
      end else begin
         sck_prev <= sck_eff;
         case (st)
            ST_IDLE: if (tx_take) begin
               tsr    <= tx_byte;
               bitcnt <= '0;
               st     <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (!en) st <= ST_IDLE;
               else if (rise) begin
                  rsr <= rx_byte;
                  if (last_bit) begin
                     st   <= ST_HOLD;
                     hcnt <= HCW'(HOLD_UNIT * (int'(hold_sel) + 1) - 1);
                  end else begin
                     bitcnt <= bitcnt + 1'b1;
                  end
               end else if (fall) begin
                  tsr <= lsb_first ? (tsr >> 1) : (tsr << 1);
               end
            end
            ST_HOLD: begin
               if (hcnt == '0) st <= ST_IDLE;
               else            hcnt <= hcnt - 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // master-mode clock generator: runs while shifting, then finishes its high phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         sck_gen <= 1'b0;
      end else if (en && master && (st == ST_SHIFT || sck_gen)) begin
         if (div_cnt == DCW'(HALF_DIV - 1)) begin
            div_cnt <= '0;
            sck_gen <= ~sck_gen;
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end else begin
         div_cnt <= '0;
         sck_gen <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_eng_pad.sv
module spi_eng_pad (
   input  logic active,
   input  logic val,
   input  logic od,
   output logic pad_o,
   output logic pad_oe
);
   always_comb begin
      if (od) begin
         pad_o  = 1'b0;
         pad_oe = active & ~val;
      end else begin
         pad_o  = val;
         pad_oe = active;
      end
   end
endmodule

// File: rtl/spi_eng.sv
module spi_eng
   import spi_eng_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SYNC_N    = 2,
   parameter int HOLD_UNIT = 8,
   parameter int HALF_DIV  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              sdo_oe,
   output logic              irq
);
   localparam int NPAD = 2;

   if (DATA_W != 8)    begin : g_bad_w    $error("DATA_W must be 8 for the byte bus"); end
   if (SYNC_N < 1)     begin : g_bad_sync $error("SYNC_N must be at least 1"); end
   if (HOLD_UNIT < 1)  begin : g_bad_hold $error("HOLD_UNIT must be at least 1"); end
   if (HALF_DIV < 2)   begin : g_bad_div  $error("HALF_DIV must be at least 2"); end

   cfg_t              cfg;
   logic              en, master, ie, done, full, tx_pend, tx_take, rx_load, xfer_done;
   logic              sdo_bit, sck_gen, hold, od_sdo, od_sck;
   logic [DATA_W-1:0] tx_byte, rx_byte;
   logic [NPAD-1:0]   p_act, p_val, p_od, p_o, p_oe;
   logic              unused_full;

   assign unused_full = full;

   spi_eng_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .rx_load(rx_load), .rx_byte(rx_byte),
      .tx_take(tx_take), .xfer_done(xfer_done), .cfg(cfg), .en(en), .master(master),
      .ie(ie), .done(done), .full(full), .tx_pend(tx_pend), .tx_byte(tx_byte)
   );

   spi_eng_shift #(.DATA_W(DATA_W), .SYNC_N(SYNC_N), .HOLD_UNIT(HOLD_UNIT),
                   .HALF_DIV(HALF_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(en), .master(master),
      .lsb_first(cfg.lsb_first), .hold_sel(cfg.hold_sel), .tx_pend(tx_pend),
      .tx_byte(tx_byte), .sck_in(sck_i), .sdi_in(sdi_i), .tx_take(tx_take),
      .rx_load(rx_load), .rx_byte(rx_byte), .xfer_done(xfer_done),
      .sdo_bit(sdo_bit), .sck_gen(sck_gen), .hold(hold)
   );

   assign od_sdo = cfg.od_sdo;
   assign od_sck = cfg.od_sck;

   // pad 0 = serial data out, pad 1 = serial clock
   assign p_act = {en & master, en};
   assign p_val = {sck_gen, sdo_bit};
   assign p_od  = {od_sck, od_sdo};

   for (genvar g = 0; g < NPAD; g++) begin : g_pad
      spi_eng_pad u_pad (
         .active(p_act[g]), .val(p_val[g]), .od(p_od[g]),
         .pad_o(p_o[g]), .pad_oe(p_oe[g])
      );
   end

   assign sdo_o  = p_o[0];
   assign sdo_oe = p_oe[0];
   assign sck_o  = p_o[1];
   assign sck_oe = p_oe[1];
   assign irq    = done & ie;
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
   input logic clk,
   input logic rst_n,
   input logic irq,
   input logic ie,
   input logic done,
   input logic sdo_o,
   input logic sck_o,
   input logic sck_oe,
   input logic od_sdo,
   input logic od_sck,
   input logic master,
   input logic hold,
   input logic sdo_bit
);
   p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie && done));
   p_od_sdo_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      od_sdo |-> (sdo_o == 1'b0));
   p_od_sck_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      od_sck |-> !sck_o);
   p_slave_no_sck_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !master |-> !sck_oe);
   p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && $past(hold)) |-> $stable(sdo_bit));
   p_done_after_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(hold));
endmodule

bind spi_eng spi_eng_chk u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .ie(ie), .done(done),
   .sdo_o(sdo_o), .sck_o(sck_o), .sck_oe(sck_oe), .od_sdo(od_sdo),
   .od_sck(od_sck), .master(master), .hold(hold), .sdo_bit(sdo_bit)
);

// File: tb/spi_eng_test.sv
module spi_eng_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       sck_i = 1'b0, sdi_i = 1'b0;
   logic       sck_o, sck_oe, sdo_o, sdo_oe, irq;
   int         cyc = 0;
   int         checks = 0;
   int         fails = 0;

   typedef struct packed {
      logic [7:0] tx;
      logic [7:0] sdi;
      logic       lsb;
      logic [1:0] hsel;
   } vec_t;

   localparam vec_t VEC [0:5] = '{
      '{8'hA5, 8'h3C, 1'b0, 2'd0},
      '{8'h81, 8'h7E, 1'b1, 2'd1},
      '{8'h1F, 8'hC4, 1'b0, 2'd2},
      '{8'hC4, 8'h1F, 1'b1, 2'd3},
      '{8'h01, 8'h80, 1'b0, 2'd3},
      '{8'hF0, 8'h0D, 1'b1, 2'd0}
   };

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   spi_eng uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi_i(sdi_i),
      .sdo_o(sdo_o), .sdo_oe(sdo_oe), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      sck_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk) bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk) bus_rd = 1'b0;
   endtask

   function automatic logic [7:0] rev8(input logic [7:0] v);
      for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
   endfunction

   // acts as an external mode-0 master; returns the SDO sequence in send order
   task automatic xfer(input logic [7:0] sdi_b, input logic lsb,
                       output logic [7:0] seq, output int delta, output int bad);
      int c0;
      logic lastb;
      seq = '0; delta = -1; bad = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk) sdi_i = lsb ? sdi_b[i] : sdi_b[7-i];
         repeat (4) @(negedge clk);
         seq = {seq[6:0], sdo_o};
         sck_i = 1'b1;
         c0 = cyc;
         if (i == 7) begin
            lastb = sdo_o;
            for (int k = 0; k < 100 && !irq; k++) begin
               @(negedge clk);
               if (!irq && sdo_o !== lastb) bad++;
            end
            delta = cyc - c0;
         end else begin
            repeat (8) @(negedge clk);
         end
         sck_i = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d, seq;
      int delta, bad, nh, rises;
      logic prev_line, line;

      do_reset();
      // R1 reset state
      check("R1 sdo_oe", sdo_oe, 0);
      check("R1 sck_oe", sck_oe, 0);
      check("R1 irq", irq, 0);
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         check("R1 reg zero", d, 0);
      end

      // R10 reserved bits read 0
      wr(2'd2, 8'hFF);
      rd(2'd2, d);
      check("R10 status reserved", d, 8'hEC);
      wr(2'd3, 8'h7B);
      rd(2'd3, d);
      check("R10 control reserved", d, 8'h03);
      wr(2'd1, 8'h5A);
      rd(2'd1, d);
      check("R10 tx readback", d, 8'h5A);

      // R4 edges ignored while disabled
      do_reset();
      wr(2'd1, 8'hFF);
      xfer(8'hAA, 1'b0, seq, delta, bad);
      rd(2'd2, d);
      check("R4 no receive when disabled", d[0], 0);
      check("R4 no irq when disabled", irq, 0);
      do_reset();

      // vector table: both orders, every hold code
      foreach (VEC[v]) begin
         nh = 8 * (int'(VEC[v].hsel) + 1);
         wr(2'd2, {VEC[v].lsb, VEC[v].hsel, 5'b0});
         wr(2'd1, VEC[v].tx);
         wr(2'd3, 8'h05);
         repeat (10) @(negedge clk);
         check("R4 waits for clock", irq, 0);
         check("R4 first bit shown", sdo_o, VEC[v].lsb ? VEC[v].tx[0] : VEC[v].tx[7]);
         xfer(VEC[v].sdi, VEC[v].lsb, seq, delta, bad);
         if (VEC[v].lsb) check("R3 lsb-first send order", seq, rev8(VEC[v].tx));
         else            check("R2 msb-first send order", seq, VEC[v].tx);
         check("R6 hold window", (delta >= nh && delta <= nh + 5) ? 1 : 0, 1);
         check("R6 last bit held", bad, 0);
         check("R6 idle level after hold", sdo_o, 1);
         check("R7 irq raised", irq, 1);
         rd(2'd3, d);
         check("R6 done flag", d, 8'h85);
         rd(2'd2, d);
         check("R5 full flag set", d[0], 1);
         rd(2'd0, d);
         if (VEC[v].lsb) check("R3 received byte", d, VEC[v].sdi);
         else            check("R2 received byte", d, VEC[v].sdi);
         rd(2'd2, d);
         check("R5 full cleared by read", d[0], 0);
         wr(2'd3, 8'h85);
         check("R7 writing 1 keeps done", irq, 1);
         wr(2'd3, 8'h05);
         check("R7 writing 0 clears done", irq, 0);
      end

      // R7 interrupt masked
      wr(2'd2, 8'h00);
      wr(2'd1, 8'h3C);
      wr(2'd3, 8'h01);
      xfer(8'h55, 1'b0, seq, delta, bad);
      check("R7 masked irq", irq, 0);
      rd(2'd3, d);
      check("R7 done without irq", d, 8'h81);
      wr(2'd3, 8'h01);

      // R8 open-drain data pad
      wr(2'd2, 8'h08);
      @(negedge clk);
      check("R8 idle released oe", sdo_oe, 0);
      check("R8 value held low", sdo_o, 0);
      wr(2'd1, 8'h00);
      repeat (4) @(negedge clk);
      check("R8 drive low oe", sdo_oe, 1);
      xfer(8'h00, 1'b0, seq, delta, bad);
      check("R8 line pulled low for zeros", seq, 8'h00);
      wr(2'd3, 8'h01);

      // R9 master mode with open-drain clock
      do_reset();
      sdi_i = 1'b1;
      wr(2'd2, 8'h04);
      wr(2'd3, 8'h07);
      @(negedge clk);
      check("R9 master idle drives low", sck_oe, 1);
      wr(2'd1, 8'h96);
      rises = 0;
      prev_line = 1'b0;
      for (int k = 0; k < 400 && !irq; k++) begin
         @(negedge clk);
         line = sck_oe ? sck_o : 1'b1;
         if (line && !prev_line) rises++;
         prev_line = line;
         if (sck_o !== 1'b0) rises = rises + 100;
      end
      check("R9 eight clock pulses", rises, 8);
      check("R9 transfer completes", irq, 1);
      rd(2'd0, d);
      check("R9 master received", d, 8'hFF);
      wr(2'd3, 8'h00);
      @(negedge clk);
      check("R9 slave clock released", sck_oe, 0);

      finish_run();
   end
endmodule